// File: doc/BRIEF.md
# Triggered Four-Pulse Timing Sequencer

This block turns one asynchronous trigger edge into a fixed train of four short pulses, each on its own output line. The pulses form two pairs. A short, configurable gap separates the two pulses of a pair. A second gap, programmable over a much wider range, separates the end of the first pair from the start of the second. A typical use is driving isolated switch drivers in a pulsed high-voltage stage. There, one external event must open and close devices in a strict order, with no spurious edges.

All timing comes from the system clock, which is 100 MHz nominally, so one count is 10 ns. The trigger passes through a synchronizer and an edge detector. An accepted edge loads the three timing settings into shadow registers, clears a running counter, and raises the busy flag. Each output line is a set/reset flop. It sets when the counter equals that line's start value and clears when the counter equals its end value. Busy drops on the same clock edge as the last pulse's trailing edge. Trigger edges that arrive while busy is high are discarded.

Top module: `pulse_train_seq`

## Requirements
- R1: After reset, and whenever busy is low, all four pulse lines and busy are low.
- R2: A rising edge on the trigger starts a sequence. If the trigger is first sampled high at clock edge E0, busy rises at edge E0+2 and `pulse_o[0]` rises at edge E0+3. That is a latency of at most 40 ns at 100 MHz.
- R3: Every pulse is high for exactly W clock cycles, where W is the width setting.
- R4: `pulse_o[1]` rises exactly G cycles after `pulse_o[0]` falls, and `pulse_o[3]` rises exactly G cycles after `pulse_o[2]` falls. G is the pair-gap setting.
- R5: `pulse_o[2]` rises exactly D cycles after `pulse_o[1]` falls, where D is the set-gap setting. D spans its full 16-bit range (1 to 65535 cycles).
- R6: The lines fire in index order 0, 1, 2, 3, and at most one line is high at any time.
- R7: Busy stays high from the accepted trigger until the clock edge on which `pulse_o[3]` falls, and drops on that edge.
- R8: A trigger rising edge that arrives while busy is high produces no pulse and no change in timing. A trigger held high produces only one sequence.
- R9: The W, G and D settings are captured when the trigger is accepted. Changes to them during a sequence do not affect that sequence.
- R10: A width or gap setting of zero is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_async | input | 1 | Trigger input, asynchronous to clk |
| cfg_width | input | 8 | Pulse width W in clock cycles |
| cfg_pair_gap | input | 8 | Gap G inside each pair, in cycles |
| cfg_set_gap | input | 16 | Gap D between the two pairs, in cycles |
| pulse_o | output | 4 | Pulse lines, index 0 fires first |
| busy_o | output | 1 | High while a sequence is running |

## Verification
Everything is timed from the negative clock edge at which the bench raises the trigger, cycle c. Busy is due high at c+3. Line k must rise at c+4 plus its start offset: 0, W+G, 2W+G+D and 3W+2G+D for lines 0 to 3. Each line must fall W cycles after it rises. Busy is still high at c+3+4W+2G+D and low one cycle later.

The driver pushes those cycle numbers into a queue when it raises the trigger. A monitor samples every negative edge, pops the queue on each observed rising edge, and compares the cycle numbers exactly. Any rising edge for which no entry was queued is flagged, which is how re-trigger rejection is checked.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  // Number of output lines in one train (two pairs).
  localparam int NUM_LINES = 4;
  // Count of set/clear marks along the train.
  localparam int NUM_MARKS = 2 * NUM_LINES;
  // Default synchronizer depth for the trigger.
  localparam int SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_async,
  output logic rise_o
);
  // sh[0..DEPTH-1] is the synchronizer, sh[DEPTH] holds the previous level.
  logic [DEPTH:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[DEPTH-1:0], trig_async};
  end

  assign rise_o = sh[DEPTH-1] & ~sh[DEPTH];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);  // R8
endmodule

// File: rtl/seq_timer.sv
module seq_timer
  import pulse_seq_pkg::*;
#(
  parameter int W_W   = 8,
  parameter int G_W   = 8,
  parameter int D_W   = 16,
  parameter int CNT_W = 17
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_edge,
  input  logic [W_W-1:0]                    cfg_w,
  input  logic [G_W-1:0]                    cfg_g,
  input  logic [D_W-1:0]                    cfg_d,
  output logic                              busy_o,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic [NUM_LINES-1:0][CNT_W-1:0]   set_at_o,
  output logic [NUM_LINES-1:0][CNT_W-1:0]   clr_at_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W_W-1:0]   w_q;
  logic [G_W-1:0]   g_q;
  logic [D_W-1:0]   d_q;
  logic             accept;
  logic [CNT_W-1:0] w_ext, g_ext, d_ext;
  logic [CNT_W-1:0] mark [NUM_MARKS];

  assign accept = start_edge & ~busy_q;

  // Shadowed settings, counter and busy flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      w_q    <= W_W'(1);
      g_q    <= G_W'(1);
      d_q    <= D_W'(1);
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      w_q    <= (cfg_w == '0) ? W_W'(1) : cfg_w;
      g_q    <= (cfg_g == '0) ? G_W'(1) : cfg_g;
      d_q    <= (cfg_d == '0) ? D_W'(1) : cfg_d;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == mark[NUM_MARKS-1]) busy_q <= 1'b0;
    end
  end

  assign w_ext = CNT_W'(w_q);
  assign g_ext = CNT_W'(g_q);
  assign d_ext = CNT_W'(d_q);

  // Cumulative marks: w, g, w, d, w, g, w between consecutive marks.
  assign mark[0] = '0;
  for (genvar i = 1; i < NUM_MARKS; i++) begin : g_mark
    if (i == NUM_MARKS / 2) begin : g_set_gap
      assign mark[i] = mark[i-1] + d_ext;
    end else if (i % 2 == 1) begin : g_width
      assign mark[i] = mark[i-1] + w_ext;
    end else begin : g_pair_gap
      assign mark[i] = mark[i-1] + g_ext;
    end
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_out
    assign set_at_o[k] = mark[2*k];
    assign clr_at_o[k] = mark[2*k+1];
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;

  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(w_q) && $stable(g_q) && $stable(d_q)));  // R9

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_edge) |=> (cnt_q != '0));  // R8

  AST_NONZERO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (w_q != '0 && g_q != '0 && d_q != '0));  // R10
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
  import pulse_seq_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            busy,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [NUM_LINES-1:0][CNT_W-1:0] set_at,
  input  logic [NUM_LINES-1:0][CNT_W-1:0] clr_at,
  output logic [NUM_LINES-1:0]            line_o
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)                          line_o[k] <= 1'b0;
      else if (busy && cnt == set_at[k])   line_o[k] <= 1'b1;
      else if (busy && cnt == clr_at[k])   line_o[k] <= 1'b0;
    end
  end

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_o));  // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (line_o == '0));  // R1
endmodule

// File: rtl/pulse_train_seq.sv
module pulse_train_seq
  import pulse_seq_pkg::*;
#(
  parameter int W_W        = 8,
  parameter int G_W        = 8,
  parameter int D_W        = 16,
  parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig_async,
  input  logic [W_W-1:0]       cfg_width,
  input  logic [G_W-1:0]       cfg_pair_gap,
  input  logic [D_W-1:0]       cfg_set_gap,
  output logic [NUM_LINES-1:0] pulse_o,
  output logic                 busy_o
);
  // 4 widths + 2 pair gaps fit in max(W_W,G_W)+3 bits; add the set gap.
  localparam int WG_W  = ((W_W > G_W) ? W_W : G_W) + 3;
  localparam int CNT_W = ((D_W > WG_W) ? D_W : WG_W) + 1;

  logic                            rise;
  logic                            busy;
  logic [CNT_W-1:0]                cnt;
  logic [NUM_LINES-1:0][CNT_W-1:0] set_at;
  logic [NUM_LINES-1:0][CNT_W-1:0] clr_at;

  trig_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_async (trig_async),
    .rise_o     (rise)
  );

  seq_timer #(.W_W(W_W), .G_W(G_W), .D_W(D_W), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_edge (rise),
    .cfg_w      (cfg_width),
    .cfg_g      (cfg_pair_gap),
    .cfg_d      (cfg_set_gap),
    .busy_o     (busy),
    .cnt_o      (cnt),
    .set_at_o   (set_at),
    .clr_at_o   (clr_at)
  );

  pulse_gen #(.CNT_W(CNT_W)) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .cnt    (cnt),
    .set_at (set_at),
    .clr_at (clr_at),
    .line_o (pulse_o)
  );

  assign busy_o = busy;

  AST_BUSY_ENDS_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $fell(pulse_o[NUM_LINES-1]));  // R7

  AST_FIRST_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o[0]) |-> $past(busy_o));  // R2
endmodule

// File: tb/pulse_train_seq_tb.sv
module pulse_train_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [7:0]  cw = 8'd5;
  logic [7:0]  cg = 8'd5;
  logic [15:0] cd = 16'd10;
  logic [3:0]  pulse;
  logic        busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_train_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_async   (trig),
    .cfg_width    (cw),
    .cfg_pair_gap (cg),
    .cfg_set_gap  (cd),
    .pulse_o      (pulse),
    .busy_o       (busy)
  );

  typedef struct {
    int    line;
    int    rise;
    int    width;
    string tag;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         nchk = 0;
  int         nfail = 0;
  int         fall_due [4];
  logic [3:0] prev = 4'b0;
  bit         done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // Monitor: pops the scoreboard on every observed rising edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check($countones(pulse) <= 1, "R6 lines active at once", $countones(pulse), 1);
      for (int k = 0; k < 4; k++) begin
        if (pulse[k] && !prev[k]) begin
          if (sb.size() == 0) begin
            check(1'b0, "R8 unexpected rise on line", k, -1);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.line == k, {e.tag, " line order"}, k, e.line);
            check(e.rise == cyc, {e.tag, " rise cycle"}, cyc, e.rise);
            fall_due[k] = cyc + e.width;
          end
        end
        if (!pulse[k] && prev[k])
          check(cyc == fall_due[k], "R3 fall cycle", cyc, fall_due[k]);
      end
      prev = pulse;
    end
  end

  // Driver: raises the trigger, queues the expected edges, checks busy.
  task automatic run_seq(input int w, input int g, input int d,
                         input bit retrig, input bit cfgchg, input string tag);
    int we, ge, de, c, last;
    int st [4];
    we = (w == 0) ? 1 : w;
    ge = (g == 0) ? 1 : g;
    de = (d == 0) ? 1 : d;
    st[0] = 0;
    st[1] = we + ge;
    st[2] = 2*we + ge + de;
    st[3] = 3*we + 2*ge + de;
    last  = 4*we + 2*ge + de;
    @(negedge clk);
    cw = 8'(w); cg = 8'(g); cd = 16'(d);
    trig = 1'b1;
    c = cyc;
    for (int k = 0; k < 4; k++) begin
      exp_t e;
      e.line  = k;
      e.rise  = c + 4 + st[k];
      e.width = we;
      e.tag   = (tag != "") ? tag : ((k == 0) ? "R2" : ((k == 2) ? "R5" : "R4"));
      sb.push_back(e);
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    if (cfgchg) begin
      cw = cw + 8'd3; cg = cg + 8'd2; cd = cd + 16'd7;  // R9
    end
    if (retrig) begin
      trig = 1'b0;
      repeat (2) @(negedge clk);
      trig = 1'b1;  // R8: edge while busy
      repeat (2) @(negedge clk);
    end
    while (cyc < c + 3 + last) @(negedge clk);
    check(busy == 1'b1, "R7 busy before last fall", busy, 1);
    @(negedge clk);
    check(busy == 1'b0, "R7 busy after last fall", busy, 0);
    check(pulse == 4'b0, "R1 lines low when idle", pulse, 0);
    trig = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(pulse == 4'b0, "R1 lines in reset", pulse, 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(pulse == 4'b0 && busy == 1'b0, "R1 idle after reset", {busy, pulse}, 0);

    run_seq(5, 5, 10, 1'b0, 1'b0, "");       // nominal train
    run_seq(5, 7, 1000, 1'b0, 1'b0, "");     // long set gap, R5
    run_seq(1, 1, 1, 1'b0, 1'b0, "");        // minimum spacing, R6
    run_seq(0, 0, 0, 1'b0, 1'b0, "R10");     // zeros act as one
    run_seq(5, 5, 50, 1'b1, 1'b0, "R8");     // re-trigger ignored
    run_seq(4, 6, 30, 1'b0, 1'b1, "R9");     // settings changed mid-run
    run_seq(8, 10, 200, 1'b0, 1'b0, "");     // back to back
    run_seq(8, 10, 200, 1'b0, 1'b0, "");
    run_seq(255, 255, 65535, 1'b0, 1'b0, "R5");  // full range

    check(sb.size() == 0, "R2 all queued pulses seen", sb.size(), 0);
    finish_up();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule